// File: doc/BRIEF.md
# Two-Layer Threshold-Gate Population Counter

This block counts the ones in a 7-bit or 15-bit input word and returns the count in binary. A parameter picks the width. It does not use a tree of full adders. Each output bit comes from a threshold gate, modelled as "weighted sum minus threshold is at least zero". The plain count of the input bits, with every bit weighted 1, is formed once and shared by every gate.

The gates sit in two layers:

- The first layer compares the shared sum against every even threshold up to one below the input count. The gate whose threshold equals the top power of two drives the most significant output bit.
- The second layer produces each lower output bit. It adds negative multiples of selected first-layer outputs to the shared sum. This isolates the ranges of the sum in which that bit is 1.

Every gate output is a dual-rail pair. Both rails read 0 during precharge, and exactly one rail reads 1 after evaluation. Evaluation runs on a clock and follows a start signal:

- Raising `start_i` lets the first layer evaluate.
- The completion of one first-layer gate releases the whole second layer.
- `valid_o` rises once every output pair is complete.
- Dropping `start_i` returns every gate to precharge.

The input word must be held stable while `start_i` is high.

Top module: `thr_popcount`

## Requirements
- R1: In the cycles after a synchronous active-low reset, `valid_o` is 0 and every bit of both `count_o` and `count_n_o` is 0.
- R2: After a clock edge at which `start_i` was sampled low (precharge), every bit of `count_o` and `count_n_o` is 0.
- R3: Whenever `valid_o` is 1, `count_o` equals the number of ones in `bits_i`. This holds for every input word, for both WIDTH=7 (3-bit count) and WIDTH=15 (4-bit count).
- R4: Whenever `valid_o` is 1, `count_n_o` is the bitwise complement of `count_o`. At no time do both rails of a bit read 1.
- R5: With `start_i` first sampled high at edge k and held, `valid_o` is 0 after edge k and 1 after edge k+1. It then stays 1 with an unchanged count while `start_i` and `bits_i` stay unchanged.
- R6: After edge k (first layer only), the most significant output bit already has one rail set to its correct value. Every lower bit still reads 0 on both rails, because the second layer is held in precharge until the first layer completes.
- R7: `valid_o` falls in the same cycle that `start_i` is driven low, before any clock edge, so a result is never flagged valid while precharge is being requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | High: evaluate; low: precharge |
| bits_i | input | WIDTH | Input word whose ones are counted |
| count_o | output | CW = $clog2(WIDTH+1) | True rail of the count |
| count_n_o | output | CW | Complement rail of the count |
| valid_o | output | 1 | All output pairs complete and start still high |

## Verification
The results appear on fixed cycles after `start_i` is first sampled high at edge k:

- The top bit and the still-empty lower rails are due after edge k.
- The full count and `valid_o` are due after edge k+1.
- The fall of `valid_o` is due within the same cycle that `start_i` drops.
- All-zero rails are due after the next edge.

The bench drives inputs on the falling clock edge and reads the outputs on the following falling edges, one per stage. It checks `valid_o` a short delay after lowering `start_i`, with no rising edge in between. Every input word of both widths is applied through this same sequence.

// File: rtl/thr_popcount_pkg.sv
// Package: shared types for the threshold-gate population counter.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package thr_popcount_pkg;

    // Dual-rail gate output: hi is the true rail, lo the complement rail.
    // Both 0 means precharge; exactly one set means evaluated.
    typedef struct packed {
        logic hi;
        logic lo;
    } rail_t;

    // Width of the signed weighted sum seen by a gate, given count width.
    function automatic int sum_width(input int cw);
        return cw + 2;
    endfunction

endpackage

// File: rtl/thr_sum.sv
// Module: thr_sum
// Forms the shared unit-weight sum of all input bits once; every gate in
// both layers reads this one value. Purely combinational.
// Assumes CW is wide enough to hold WIDTH.
module thr_sum #(
    parameter int WIDTH = 15,
    parameter int CW    = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] bits_i,
    output logic [CW-1:0]    sum_o
);

    // Accumulate every bit with weight one.
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            sum_o = sum_o + CW'(bits_i[i]);
        end
    end

endmodule

// File: rtl/thr_gate.sv
// Module: thr_gate
// Behavioural threshold gate with a registered dual-rail output. When
// eval_i is sampled high the gate resolves sum_i >= THRESH onto one rail;
// when low both rails precharge to 0. done_o is the NAND of the inverted
// rails, i.e. high once either rail is set.
// Assumes sum_i is stable while eval_i is high.
module thr_gate
    import thr_popcount_pkg::*;
#(
    parameter int SW     = 6,
    parameter int THRESH = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eval_i,
    input  logic signed [SW-1:0] sum_i,
    output rail_t                rail_o,
    output logic                 done_o
);

    localparam logic signed [SW-1:0] TH = SW'(THRESH);

    logic fire;

    // Threshold decision: weighted sum minus threshold is non-negative.
    always_comb fire = (sum_i >= TH);

    // Rail register: precharge on reset or idle, resolve on evaluate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rail_o <= '0;
        end else if (!eval_i) begin
            rail_o <= '0;
        end else begin
            rail_o.hi <= fire;
            rail_o.lo <= ~fire;
        end
    end

    // Completion detect: NAND of the two inverted rails.
    always_comb done_o = ~((~rail_o.hi) & (~rail_o.lo));

    // R4: a gate never drives both rails high.
    a_r4_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rail_o.hi && rail_o.lo));

    // R2: an idle edge leaves both rails precharged.
    a_r2_gate_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> (rail_o == '0));

endmodule

// File: rtl/thr_layer1.sv
// Module: thr_layer1
// First layer: one gate per even threshold 2, 4, ... WIDTH-1, all reading
// the shared sum. Gate g has threshold 2*(g+1). done_o is the completion
// of gate 0 and releases the second layer.
// Assumes WIDTH is odd (7 or 15).
module thr_layer1
    import thr_popcount_pkg::*;
#(
    parameter int WIDTH = 15,
    parameter int CW    = $clog2(WIDTH + 1),
    parameter int NG    = (WIDTH - 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CW-1:0]     sum_i,
    output rail_t [NG-1:0]    rails_o,
    output logic              done_o
);

    localparam int SW = sum_width(CW);

    logic signed [SW-1:0] sum_s;
    logic [NG-1:0]        done_v;

    // Zero-extend the shared sum into the signed gate domain.
    always_comb sum_s = $signed({2'b00, sum_i});

    for (genvar g = 0; g < NG; g++) begin : g_gate
        thr_gate #(
            .SW     (SW),
            .THRESH (2 * (g + 1))
        ) i_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .eval_i (start_i),
            .sum_i  (sum_s),
            .rail_o (rails_o[g]),
            .done_o (done_v[g])
        );
    end

    // One gate's completion enables the whole second layer.
    always_comb done_o = done_v[0];

    // R6: first-layer rails only appear after an edge with start sampled high.
    a_r6_l1_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i));

endmodule

// File: rtl/thr_layer2.sv
// Module: thr_layer2
// Second layer: one gate per lower output bit j. Its weighted sum is the
// shared sum minus 2^(j+1) for every first-layer output whose threshold is
// a multiple of 2^(j+1); its threshold is 2^j. Gates evaluate only while
// start is high and the first layer has completed.
// Assumes first-layer gate g has threshold 2*(g+1).
module thr_layer2
    import thr_popcount_pkg::*;
#(
    parameter int WIDTH = 15,
    parameter int CW    = $clog2(WIDTH + 1),
    parameter int NG    = (WIDTH - 1) / 2,
    parameter int NL    = CW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [CW-1:0]     sum_i,
    input  rail_t [NG-1:0]    l1_rails_i,
    output rail_t [NL-1:0]    rails_o
);

    localparam int SW = sum_width(CW);

    for (genvar j = 0; j < NL; j++) begin : g_bit
        localparam int STEP = 2 ** (j + 1);

        logic signed [SW-1:0] wsum;
        logic                 done_unused;

        // Weighted sum: shared sum with negative first-layer feedback.
        always_comb begin
            int acc;
            acc = int'(sum_i);
            for (int g = 0; g < NG; g++) begin
                if (l1_rails_i[g].hi && ((2 * (g + 1)) % STEP == 0)) begin
                    acc = acc - STEP;
                end
            end
            wsum = SW'(acc);
        end

        thr_gate #(
            .SW     (SW),
            .THRESH (2 ** j)
        ) i_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .eval_i (eval_i),
            .sum_i  (wsum),
            .rail_o (rails_o[j]),
            .done_o (done_unused)
        );

        // R3: a feedback-adjusted sum never goes negative once layer 1 settled.
        a_r3_wsum_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
            eval_i |-> (wsum >= 0));
    end

    // R6: the second layer stays precharged unless released on the prior edge.
    a_r6_l2_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rails_o != '0) |-> $past(eval_i));

endmodule

// File: rtl/thr_popcount.sv
// Module: thr_popcount (top)
// Population counter of WIDTH (7 or 15) bits built as two layers of
// threshold gates with dual-rail outputs and self-timed layer release.
// Top bit comes from the first layer; lower bits from the second.
// Assumes bits_i is held stable while start_i is high.
module thr_popcount
    import thr_popcount_pkg::*;
#(
    parameter int WIDTH = 15,
    parameter int CW    = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] bits_i,
    output logic [CW-1:0]    count_o,
    output logic [CW-1:0]    count_n_o,
    output logic             valid_o
);

    localparam int NG      = (WIDTH - 1) / 2;
    localparam int NL      = CW - 1;
    localparam int MSB_IDX = (2 ** (CW - 1)) / 2 - 1;

    logic [CW-1:0]  vsum;
    rail_t [NG-1:0] l1_rails;
    rail_t [NL-1:0] l2_rails;
    logic           l1_done;
    logic           l2_eval;
    logic [CW-1:0]  complete;

    thr_sum #(.WIDTH(WIDTH), .CW(CW)) i_sum (
        .bits_i (bits_i),
        .sum_o  (vsum)
    );

    thr_layer1 #(.WIDTH(WIDTH), .CW(CW), .NG(NG)) i_l1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .sum_i   (vsum),
        .rails_o (l1_rails),
        .done_o  (l1_done)
    );

    // Second layer release: start still requested and first layer complete.
    always_comb l2_eval = start_i & l1_done;

    thr_layer2 #(.WIDTH(WIDTH), .CW(CW), .NG(NG), .NL(NL)) i_l2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .eval_i     (l2_eval),
        .sum_i      (vsum),
        .l1_rails_i (l1_rails),
        .rails_o    (l2_rails)
    );

    // Output mapping: lower bits from layer 2, top bit from layer 1.
    always_comb begin
        for (int j = 0; j < NL; j++) begin
            count_o[j]   = l2_rails[j].hi;
            count_n_o[j] = l2_rails[j].lo;
        end
        count_o[CW-1]   = l1_rails[MSB_IDX].hi;
        count_n_o[CW-1] = l1_rails[MSB_IDX].lo;
    end

    // Completion: every pair resolved, and precharge not being requested.
    always_comb begin
        complete = count_o | count_n_o;
        valid_o  = start_i & (&complete);
    end

    // R3: a flagged result is the population count of the input word.
    a_r3_count_correct: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (count_o == CW'($countones(bits_i))));

    // R4: a flagged result carries complementary rails.
    a_r4_dual_rail: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (count_n_o == ~count_o));

    // R7: no valid flag while precharge is requested.
    a_r7_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |-> !valid_o);

    // R5: valid can only rise after start was already high on the prior edge.
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(start_i));

endmodule

// File: tb/test_thr_popcount.sv
// Directed bench: two instances (7-bit and 15-bit) share clock and start.
module test_thr_popcount;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [14:0] bits15 = '0;
    logic [6:0]  bits7 = '0;
    logic [3:0]  cnt15, cnt15_n;
    logic [2:0]  cnt7, cnt7_n;
    logic        val15, val7;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    thr_popcount #(.WIDTH(15)) i_thr_popcount (
        .clk (clk), .rst_n (rst_n), .start_i (start), .bits_i (bits15),
        .count_o (cnt15), .count_n_o (cnt15_n), .valid_o (val15)
    );

    thr_popcount #(.WIDTH(7)) i_thr_popcount_7 (
        .clk (clk), .rst_n (rst_n), .start_i (start), .bits_i (bits7),
        .count_o (cnt7), .count_n_o (cnt7_n), .valid_o (val7)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [14:0] v);
        int n = 0;
        for (int i = 0; i < 15; i++) n += int'(v[i]);
        return n;
    endfunction

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(val15 == 0 && val7 == 0, "R1 valid", int'(val15), 0);
        chk(cnt15 == 0 && cnt15_n == 0, "R1 rails15", int'({cnt15, cnt15_n}), 0);
        chk(cnt7 == 0 && cnt7_n == 0, "R1 rails7", int'({cnt7, cnt7_n}), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R5 R6 R7 R2: stage-by-stage timing on one word.
    task automatic t_stages(input logic [14:0] w);
        int e15 = ones(w);
        int e7  = ones({8'b0, w[6:0]});
        bits15 = w; bits7 = w[6:0]; start = 1'b1;
        @(negedge clk);
        chk(val15 == 0, "R5 no early valid", int'(val15), 0);
        chk(cnt15[3] == e15[3] && cnt15_n[3] == !e15[3], "R6 msb15 early",
            int'({cnt15[3], cnt15_n[3]}), int'({e15[3], !e15[3]}));
        chk(cnt15[2:0] == 0 && cnt15_n[2:0] == 0, "R6 low held15",
            int'({cnt15[2:0], cnt15_n[2:0]}), 0);
        chk(cnt7[2] == e7[2] && cnt7[1:0] == 0 && cnt7_n[1:0] == 0, "R6 7bit",
            int'({cnt7, cnt7_n}), int'({e7[2], 2'b0, !e7[2], 2'b0}));
        @(negedge clk);
        chk(val15 == 1 && int'(cnt15) == e15, "R5 R3 count15", int'(cnt15), e15);
        chk(val7 == 1 && int'(cnt7) == e7, "R5 R3 count7", int'(cnt7), e7);
        repeat (3) begin
            @(negedge clk);
            chk(val15 == 1 && int'(cnt15) == e15, "R5 hold", int'(cnt15), e15);
        end
        start = 1'b0;
        #1;
        chk(val15 == 0 && val7 == 0, "R7 valid drop", int'(val15), 0);
        @(negedge clk);
        chk(cnt15 == 0 && cnt15_n == 0 && cnt7 == 0 && cnt7_n == 0, "R2 precharge",
            int'({cnt15, cnt15_n}), 0);
    endtask

    // R3 R4: every input word of both widths.
    task automatic t_exhaustive();
        int bad = 0;
        for (int w = 0; w < 32768; w++) begin
            int e15 = ones(15'(w));
            int e7  = ones({8'b0, 7'(w)});
            bits15 = 15'(w); bits7 = 7'(w); start = 1'b1;
            repeat (2) @(negedge clk);
            if (!(val15 && int'(cnt15) == e15 && cnt15_n == ~cnt15) && bad < 5) begin
                bad++;
                chk(0, "R3 R4 word15", int'(cnt15), e15);
            end
            if (w < 128 && !(val7 && int'(cnt7) == e7 && cnt7_n == ~cnt7) && bad < 5) begin
                bad++;
                chk(0, "R3 R4 word7", int'(cnt7), e7);
            end
            start = 1'b0;
            @(negedge clk);
        end
        chk(bad == 0, "R3 exhaustive", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_stages(15'h0000);
        t_stages(15'h7fff);
        t_stages(15'h00ff);
        t_stages(15'h5a3c);
        t_exhaustive();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule